// File: doc/BRIEF.md
# Fixed Off-Time Mixed-Decay Chopper

This block is the digital current regulator for one H-bridge winding. While the bridge drives the winding, an external comparator reports when the sensed current has reached its trip level. The block then switches the bridge off for a fixed off-time and afterwards resumes driving. The off-time either uses slow decay throughout, or uses fast decay for its first portion and slow decay for the rest. Slow decay is done with synchronous rectification: both low-side FETs are on.

The block produces the four gate-enable signals of the bridge directly. Every change between two conflicting gate patterns passes through an all-off gap, so that no leg ever conducts through both FETs. The comparator input is synchronized inside the block. It is ignored during a blanking window after each turn-on and for the whole off-time. A configuration input forces mixed decay whatever the requested mode.

All times are parameters counted in clock cycles:
- `OFF_CYC`: off-time window.
- `BLANK_CYC`: blanking.
- `GAP_CYC`: crossover gap.
- `FAST_NUM`/`FAST_DEN`: the fraction of the off window that ends the fast-decay part. The default is 5/16.
- `SYNC_STAGES`: synchronizer depth.

Top module: `chopper_ctl`

## Requirements
- R1: Once blanking has elapsed, an asserted comparator in the drive phase ends the drive phase `SYNC_STAGES+1` rising edges after the raw input rises. An off window of exactly `OFF_CYC` cycles follows, then a gap of `GAP_CYC` all-off cycles, then drive again.
- R2: Gate code {hi_a,lo_a,hi_b,lo_b} sequence in mixed decay. Drive is 1001. The off window is ordered as follows:
  - `GAP_CYC` cycles of 0000;
  - fast decay 0110 until window cycle `FAST_CYC` = `OFF_CYC*FAST_NUM/FAST_DEN`;
  - `GAP_CYC` cycles of 0000;
  - slow decay 0101 for the rest of the window.
- R3: In slow decay (decay_mixed=0, force_mixed=0), the off window is `GAP_CYC` cycles of 0000 followed by 0101 for the remainder.
- R4: force_mixed=1 gives the mixed sequence of R2 even when decay_mixed=0. The decay mode is taken when the trip is accepted.
- R5: The comparator is not acted on during the first `BLANK_CYC` cycles of a drive phase. With the comparator held asserted, a drive phase lasts `BLANK_CYC+1` cycles. A trip pulse inside blanking leaves the bridge driving.
- R6: Comparator activity during the off window and the following gap has no effect on the sequence.
- R7: No leg ever has its high and low FET on in the same cycle. A FET of a leg turns on only if the opposite FET of that leg was off in the previous cycle.
- R8: With rst_n low or en low, all gates are 0 and all timers and the synchronizer clear. The first cycle after en is seen high is a drive cycle with a fresh blanking window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| en | input | 1 | Bridge enable; low forces all gates off |
| trip_raw | input | 1 | Asynchronous current-trip comparator output |
| decay_mixed | input | 1 | Requested decay: 1 mixed, 0 slow |
| force_mixed | input | 1 | Configuration: always use mixed decay |
| hi_a | output | 1 | Leg A high-side gate enable |
| lo_a | output | 1 | Leg A low-side gate enable |
| hi_b | output | 1 | Leg B high-side gate enable |
| lo_b | output | 1 | Leg B low-side gate enable |

## Verification
The embedded properties check on every cycle the following:
- no leg shoots through, and every turn-on of a FET is preceded by an off cycle on its partner;
- the blanking and off-window phases cannot be left early;
- a disable always returns the controller to idle with cleared timers.

Only the bench's scenarios can show the exact lengths and ordering of the gap, fast and slow segments for each decay setting, the comparator latency, the override by force_mixed, and that re-enabling restarts blanking.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DRIVE = 2'd1,
    PH_OFF   = 2'd2,
    PH_GAP   = 2'd3
  } phase_e;

  typedef struct packed {
    logic hi_a;
    logic lo_a;
    logic hi_b;
    logic lo_b;
  } gates_t;

  localparam gates_t GATES_NONE  = 4'b0000;
  localparam gates_t GATES_DRIVE = 4'b1001;
  localparam gates_t GATES_FAST  = 4'b0110;
  localparam gates_t GATES_SLOW  = 4'b0101;

endpackage

// File: rtl/trip_sync.sv
module trip_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d[0] = d;
    for (int i = 1; i < STAGES; i++) begin
      sr_d[i] = sr_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (clr) begin
      sr_q <= '0;
    end else begin
      sr_q <= sr_d;
    end
  end

  assign q = sr_q[STAGES-1];

endmodule

// File: rtl/chop_fsm.sv
module chop_fsm
  import chop_pkg::*;
#(
  parameter int OFF_CYC   = 6000,
  parameter int BLANK_CYC = 200,
  parameter int GAP_CYC   = 95,
  parameter int CNT_W     = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             trip_s,
  input  logic             mixed_req,
  output phase_e           phase_d,
  output logic [CNT_W-1:0] cnt_d,
  output logic             mixed_d
);

  localparam logic [CNT_W-1:0] BLANK_LIM = CNT_W'(BLANK_CYC);
  localparam logic [CNT_W-1:0] OFF_LAST  = CNT_W'(OFF_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(GAP_CYC - 1);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             mixed_q;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    mixed_d = mixed_q;
    if (!en) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
      mixed_d = 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          phase_d = PH_DRIVE;
          cnt_d   = '0;
        end
        PH_DRIVE: begin
          if (cnt_q >= BLANK_LIM && trip_s) begin
            phase_d = PH_OFF;
            cnt_d   = '0;
            mixed_d = mixed_req;
          end else if (cnt_q < BLANK_LIM) begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_OFF: begin
          if (cnt_q == OFF_LAST) begin
            phase_d = PH_GAP;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_GAP: begin
          if (cnt_q == GAP_LAST) begin
            phase_d = PH_DRIVE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      mixed_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      mixed_q <= mixed_d;
    end
  end

  // R5
  blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DRIVE && cnt_q < BLANK_LIM && en) |=> phase_q == PH_DRIVE);

  // R6
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_OFF && cnt_q != OFF_LAST && en) |=> phase_q == PH_OFF);

  // R1
  off_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_OFF && en) |=> (phase_q == PH_OFF || phase_q == PH_GAP));

  // R8
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (phase_q == PH_IDLE && cnt_q == '0));

  // R8
  start_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && en) |=> (phase_q == PH_DRIVE && cnt_q == '0));

endmodule

// File: rtl/gate_map.sv
module gate_map
  import chop_pkg::*;
#(
  parameter int FAST_CYC = 1875,
  parameter int GAP_CYC  = 95,
  parameter int CNT_W    = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  phase_e           phase_d,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic             mixed_d,
  output gates_t           gates_q
);

  localparam logic [CNT_W-1:0] GAP_END  = CNT_W'(GAP_CYC);
  localparam logic [CNT_W-1:0] FAST_END = CNT_W'(FAST_CYC);
  localparam logic [CNT_W-1:0] SEC_END  = CNT_W'(FAST_CYC + GAP_CYC);

  gates_t gates_d;

  always_comb begin
    gates_d = GATES_NONE;
    unique case (phase_d)
      PH_DRIVE: gates_d = GATES_DRIVE;
      PH_OFF: begin
        if (cnt_d < GAP_END) begin
          gates_d = GATES_NONE;
        end else if (mixed_d && cnt_d < FAST_END) begin
          gates_d = GATES_FAST;
        end else if (mixed_d && cnt_d < SEC_END) begin
          gates_d = GATES_NONE;
        end else begin
          gates_d = GATES_SLOW;
        end
      end
      default: gates_d = GATES_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gates_q <= GATES_NONE;
    end else begin
      gates_q <= gates_d;
    end
  end

  // R7
  no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gates_q.hi_a && gates_q.lo_a) && !(gates_q.hi_b && gates_q.lo_b));

  // R7
  gap_lo_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gates_q.lo_a) |-> !$past(gates_q.hi_a));

  // R7
  gap_hi_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gates_q.hi_a) |-> !$past(gates_q.lo_a));

  // R7
  gap_lo_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gates_q.lo_b) |-> !$past(gates_q.hi_b));

  // R7
  gap_hi_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gates_q.hi_b) |-> !$past(gates_q.lo_b));

endmodule

// File: rtl/chopper_ctl.sv
module chopper_ctl
  import chop_pkg::*;
#(
  parameter int OFF_CYC     = 6000,
  parameter int BLANK_CYC   = 200,
  parameter int GAP_CYC     = 95,
  parameter int FAST_NUM    = 5,
  parameter int FAST_DEN    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic trip_raw,
  input  logic decay_mixed,
  input  logic force_mixed,
  output logic hi_a,
  output logic lo_a,
  output logic hi_b,
  output logic lo_b
);

  localparam int FAST_CYC = (OFF_CYC * FAST_NUM) / FAST_DEN;
  localparam int MAX_AB   = (OFF_CYC > BLANK_CYC) ? OFF_CYC : BLANK_CYC;
  localparam int CNT_MAX  = (MAX_AB > GAP_CYC) ? MAX_AB : GAP_CYC;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);

  logic             trip_s;
  logic             mixed_req;
  phase_e           phase_d;
  logic [CNT_W-1:0] cnt_d;
  logic             mixed_d;
  gates_t           gates_q;

  assign mixed_req = decay_mixed | force_mixed;

  trip_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (!en),
    .d    (trip_raw),
    .q    (trip_s)
  );

  chop_fsm #(
    .OFF_CYC  (OFF_CYC),
    .BLANK_CYC(BLANK_CYC),
    .GAP_CYC  (GAP_CYC),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .trip_s   (trip_s),
    .mixed_req(mixed_req),
    .phase_d  (phase_d),
    .cnt_d    (cnt_d),
    .mixed_d  (mixed_d)
  );

  gate_map #(
    .FAST_CYC(FAST_CYC),
    .GAP_CYC (GAP_CYC),
    .CNT_W   (CNT_W)
  ) u_map (
    .clk    (clk),
    .rst_n  (rst_n),
    .phase_d(phase_d),
    .cnt_d  (cnt_d),
    .mixed_d(mixed_d),
    .gates_q(gates_q)
  );

  assign hi_a = gates_q.hi_a;
  assign lo_a = gates_q.lo_a;
  assign hi_b = gates_q.hi_b;
  assign lo_b = gates_q.lo_b;

  // R8
  off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !(hi_a || lo_a || hi_b || lo_b));

endmodule

// File: tb/test_chopper_ctl.sv
module test_chopper_ctl;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int OFF   = 48;
  localparam int BLANK = 8;
  localparam int GAP   = 3;
  localparam int FNUM  = 5;
  localparam int FDEN  = 16;
  localparam int SYNC  = 2;
  localparam int FAST  = (OFF * FNUM) / FDEN;

  localparam logic [3:0] C_NONE  = 4'b0000;
  localparam logic [3:0] C_DRIVE = 4'b1001;
  localparam logic [3:0] C_FAST  = 4'b0110;
  localparam logic [3:0] C_SLOW  = 4'b0101;

  // {decay_mixed, force_mixed, expected mixed sequence}
  localparam logic [2:0] VECS [0:3] = '{3'b000, 3'b101, 3'b011, 3'b111};

  logic clk, rst_n, en, trip_raw, decay_mixed, force_mixed;
  logic hi_a, lo_a, hi_b, lo_b;
  int n_cmp = 0;
  int n_bad = 0;

  chopper_ctl #(
    .OFF_CYC(OFF), .BLANK_CYC(BLANK), .GAP_CYC(GAP),
    .FAST_NUM(FNUM), .FAST_DEN(FDEN), .SYNC_STAGES(SYNC)
  ) i_chopper_ctl (
    .clk(clk), .rst_n(rst_n), .en(en), .trip_raw(trip_raw),
    .decay_mixed(decay_mixed), .force_mixed(force_mixed),
    .hi_a(hi_a), .lo_a(lo_a), .hi_b(hi_b), .lo_b(lo_b)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [3:0] gates();
    return {hi_a, lo_a, hi_b, lo_b};
  endfunction

  task automatic check_now(input logic [3:0] exp, input string req);
    n_cmp++;
    if (gates() !== exp) begin
      n_bad++;
      $display("FAIL %s: gates %b expected %b", req, gates(), exp);
    end
  endtask

  task automatic expect_seg(input logic [3:0] code, input int len, input string req);
    logic       bad;
    logic [3:0] got;
    bad = 1'b0;
    got = '0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (gates() !== code && !bad) begin
        bad = 1'b1;
        got = gates();
      end
    end
    n_cmp++;
    if (bad) begin
      n_bad++;
      $display("FAIL %s: segment of %0d cycles got %b expected %b", req, len, got, code);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; trip_raw = 1'b0; decay_mixed = 1'b0; force_mixed = 1'b0;
    repeat (4) @(negedge clk);
    check_now(C_NONE, "R8 reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_now(C_NONE, "R8 disabled");
    en = 1'b1;
    @(negedge clk);
    check_now(C_DRIVE, "R8 enable starts in drive");

    // R5: trip pulse inside blanking has no effect
    trip_raw = 1'b1;
    repeat (2) @(negedge clk);
    trip_raw = 1'b0;
    expect_seg(C_DRIVE, 40, "R5 pulse in blanking");

    // vector table: one full chopping cycle per decay setting
    for (int v = 0; v < 4; v++) begin
      decay_mixed = VECS[v][2];
      force_mixed = VECS[v][1];
      trip_raw    = 1'b1;
      expect_seg(C_DRIVE, SYNC, "R1 trip latency");
      expect_seg(C_NONE, GAP, "R7 gap entering off");
      if (VECS[v][0]) begin
        expect_seg(C_FAST, FAST - GAP, VECS[v][1] ? "R4 forced fast part" : "R2 fast part");
        expect_seg(C_NONE, GAP, "R2 gap fast to slow");
        expect_seg(C_SLOW, OFF - FAST - GAP, "R6 slow part with trip held");
      end else begin
        expect_seg(C_SLOW, OFF - GAP, "R3 slow whole window");
      end
      expect_seg(C_NONE, GAP, "R1 gap before drive");
      expect_seg(C_DRIVE, BLANK + 1, "R5 drive length with trip held");
      expect_seg(C_NONE, 1, "R5 off after blanking");
      trip_raw = 1'b0;
      en = 1'b0;
      @(negedge clk);
      check_now(C_NONE, "R8 disable mid window");
      en = 1'b1;
      @(negedge clk);
      check_now(C_DRIVE, "R8 re-enable");
      repeat (20) @(negedge clk);
    end

    // R8: disable during off window, re-enable restarts blanking
    decay_mixed = 1'b1;
    force_mixed = 1'b0;
    trip_raw = 1'b1;
    repeat (10) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check_now(C_NONE, "R8 disable during off");
    en = 1'b1;
    expect_seg(C_DRIVE, BLANK + 1, "R8 timers cleared on re-enable");
    expect_seg(C_NONE, 1, "R8 off after fresh blanking");

    // R8: asynchronous reset during off window
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_now(C_NONE, "R8 async reset");
    trip_raw = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_now(C_DRIVE, "R8 drive after reset");

    summary();
    $finish;
  end

endmodule